// File: doc/BRIEF.md
# SMBus Packet Error Code Tracker

This block watches an SMBus transaction one byte at a time, next to the bus engine that moves the bits. It keeps the CRC-8 packet error code (PEC) over every byte on the wire, including both address bytes. A master that sends data appends the value on `crc_o` in the slot the block marks. When the master is receiving, the block compares the byte that arrives in that slot with its own running value.

At each start marker the bus engine supplies a transaction-type code and a PEC-enable bit. The block knows the byte layout of every supported transaction. It expects the write address first. After that, depending on the type, it expects a command code, a repeated start followed by the read address, a byte count, and the data bytes. From the type and the count it works out which byte is the PEC. It also flags sequences that do not follow the expected layout.

Top module: `smbus_pec_tracker`

## Requirements
- R1: The CRC uses the polynomial `POLY` (default 0x07), starts from `INIT` (default 0x00), is not reflected and has no final XOR. Each byte is folded in MSB first. `crc_o` shows the updated value in the cycle after the byte strobe, and it holds when no byte and no start is presented.
- R2: A start (`start_i`) sets `crc_o` to `INIT` and clears `pec_ok_o`, `pec_err_o`, `done_o` and `frame_err_o`. It also latches `txn_type_i` and `pec_en_i` for the whole transaction.
- R3: A repeated start does not change `crc_o`. It is legal only immediately after the command code of a read type. Anywhere else inside a transaction it raises `frame_err_o`.
- R4: Type codes: 0 send byte, 1 write byte, 2 write word, 3 block write, 4 read byte, 5 read word, 6 block read, 7 invalid. The byte layout is:
  - send byte: address, one data byte;
  - write byte and write word: address, command, then 1 or 2 data bytes;
  - block write: address, command, count, then the data bytes;
  - read byte and read word: address, command, repeated start, read address, then 1 or 2 data bytes;
  - block read: address, command, repeated start, read address, count, then the data bytes.
- R5: With PEC enabled, `pec_slot_o` is high exactly while the next expected byte is the PEC, which is right after the last data byte. The PEC byte is not folded into `crc_o`. `done_o` rises after the PEC byte is accepted.
- R6: In block types the count byte gives the number of data bytes. A count of 0 goes straight to the PEC slot, or to done when PEC is off. A count above `MAX_BLOCK` raises `frame_err_o`.
- R7: For read types the PEC byte is compared with `crc_o`. A match sets `pec_ok_o` and a mismatch sets `pec_err_o`. Both flags are held until the next start and are never high together.
- R8: With PEC disabled, `pec_slot_o` never rises and `done_o` rises after the last data byte.
- R9: `frame_err_o` is set, and held until the next start, by any of these: type code 7 at a start; a byte after the transaction is complete; a byte while a repeated start is awaited; a stop before the transaction is complete.
- R10: Byte strobes before the first start after reset are ignored, so `crc_o` stays at `INIT`.
- R11: If a start, repeated start or stop arrives in the same cycle as a byte strobe, the marker is taken and the byte is dropped.
- R12: After a frame error, bytes are still folded into `crc_o` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition seen on the bus |
| rstart_i | input | 1 | Repeated start seen on the bus |
| stop_i | input | 1 | Stop condition seen on the bus |
| byte_valid_i | input | 1 | One byte has completed on the bus |
| byte_i | input | 8 | Value of that byte |
| txn_type_i | input | 3 | Transaction type, sampled at start |
| pec_en_i | input | 1 | PEC in use for this transaction, sampled at start |
| crc_o | output | 8 | Running CRC; the PEC to append on writes |
| pec_slot_o | output | 1 | Next expected byte is the PEC |
| pec_ok_o | output | 1 | Received PEC matched |
| pec_err_o | output | 1 | Received PEC mismatched |
| done_o | output | 1 | All expected bytes have been seen |
| frame_err_o | output | 1 | Byte sequence broke the transaction layout |

## Verification
The bench builds the tracker with `MAX_BLOCK` = 32 and keeps the default polynomial and initial value. The smaller limit means random block transactions cover the whole legal range of counts, both zero and the maximum, and a count of 33 reaches the overflow path without long bursts. The default polynomial lets a known check vector, ASCII "123456789" giving 0xF4, confirm the bit order.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        K_SEND   = 3'd0,
        K_WBYTE  = 3'd1,
        K_WWORD  = 3'd2,
        K_BWRITE = 3'd3,
        K_RBYTE  = 3'd4,
        K_RWORD  = 3'd5,
        K_BREAD  = 3'd6,
        K_BAD    = 3'd7
    } kind_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR_W,
        PH_CMD,
        PH_WAIT_RS,
        PH_ADDR_R,
        PH_COUNT,
        PH_DATA,
        PH_PEC,
        PH_DONE,
        PH_FAULT
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        kind_e               kind;
        logic                pec_en;
        logic [BYTE_W-1:0]   cnt;
        logic [BYTE_W-1:0]   crc;
        logic                ok;
        logic                err;
        logic                done;
        logic                ferr;
    } trk_s;

    function automatic logic is_read(kind_e k);
        return (k == K_RBYTE) || (k == K_RWORD) || (k == K_BREAD);
    endfunction

endpackage

// File: rtl/pec_crc8_step.sv
module pec_crc8_step #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] crc_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] crc_o
);
    logic [W:0][W-1:0] chain;

    assign chain[0] = crc_i;

    // one shift stage per data bit, most significant bit first
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic fb;
        assign fb = chain[i][W-1] ^ data_i[W-1-i];
        assign chain[i+1] = {chain[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = chain[W];
endmodule

// File: rtl/pec_phase_step.sv
module pec_phase_step
    import smbus_pec_pkg::*;
#(
    parameter int MAX_BLOCK = 255
) (
    input  phase_e            ph_i,
    input  kind_e             kind_i,
    input  logic              pec_en_i,
    input  logic [BYTE_W-1:0] cnt_i,
    input  logic [BYTE_W-1:0] byte_i,
    output phase_e            ph_o,
    output logic [BYTE_W-1:0] cnt_o,
    output logic              bad_o
);
    phase_e tail;

    always_comb begin
        tail  = pec_en_i ? PH_PEC : PH_DONE;
        ph_o  = ph_i;
        cnt_o = cnt_i;
        bad_o = 1'b0;
        unique case (ph_i)
            PH_ADDR_W: begin
                if (kind_i == K_SEND) begin
                    ph_o  = PH_DATA;
                    cnt_o = BYTE_W'(1);
                end else begin
                    ph_o = PH_CMD;
                end
            end
            PH_CMD: begin
                unique case (kind_i)
                    K_WBYTE:  begin ph_o = PH_DATA; cnt_o = BYTE_W'(1); end
                    K_WWORD:  begin ph_o = PH_DATA; cnt_o = BYTE_W'(2); end
                    K_BWRITE: ph_o = PH_COUNT;
                    K_RBYTE, K_RWORD, K_BREAD: ph_o = PH_WAIT_RS;
                    default:  begin ph_o = PH_FAULT; bad_o = 1'b1; end
                endcase
            end
            PH_ADDR_R: begin
                unique case (kind_i)
                    K_RBYTE: begin ph_o = PH_DATA; cnt_o = BYTE_W'(1); end
                    K_RWORD: begin ph_o = PH_DATA; cnt_o = BYTE_W'(2); end
                    K_BREAD: ph_o = PH_COUNT;
                    default: begin ph_o = PH_FAULT; bad_o = 1'b1; end
                endcase
            end
            PH_COUNT: begin
                if (int'(byte_i) > MAX_BLOCK) begin
                    ph_o  = PH_FAULT;
                    bad_o = 1'b1;
                end else if (byte_i == '0) begin
                    ph_o = tail;
                end else begin
                    ph_o  = PH_DATA;
                    cnt_o = byte_i;
                end
            end
            PH_DATA: begin
                if (cnt_i == BYTE_W'(1)) begin
                    ph_o  = tail;
                    cnt_o = '0;
                end else begin
                    cnt_o = cnt_i - BYTE_W'(1);
                end
            end
            PH_PEC:  ph_o = PH_DONE;
            PH_WAIT_RS, PH_DONE: begin
                ph_o  = PH_FAULT;
                bad_o = 1'b1;
            end
            default: ph_o = ph_i;
        endcase
    end
endmodule

// File: rtl/smbus_pec_tracker.sv
module smbus_pec_tracker
    import smbus_pec_pkg::*;
#(
    parameter logic [7:0] POLY      = 8'h07,
    parameter logic [7:0] INIT      = 8'h00,
    parameter int         MAX_BLOCK = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rstart_i,
    input  logic       stop_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    input  logic [2:0] txn_type_i,
    input  logic       pec_en_i,
    output logic [7:0] crc_o,
    output logic       pec_slot_o,
    output logic       pec_ok_o,
    output logic       pec_err_o,
    output logic       done_o,
    output logic       frame_err_o
);
    trk_s              st_d, st_q;
    logic [BYTE_W-1:0] crc_nx;
    phase_e            ph_nx;
    logic [BYTE_W-1:0] cnt_nx;
    logic              bad_nx;
    kind_e             kind_in;

    assign kind_in = kind_e'(txn_type_i);

    pec_crc8_step #(.W(BYTE_W), .POLY(POLY)) u_crc (
        .crc_i  (st_q.crc),
        .data_i (byte_i),
        .crc_o  (crc_nx)
    );

    pec_phase_step #(.MAX_BLOCK(MAX_BLOCK)) u_phase (
        .ph_i     (st_q.ph),
        .kind_i   (st_q.kind),
        .pec_en_i (st_q.pec_en),
        .cnt_i    (st_q.cnt),
        .byte_i   (byte_i),
        .ph_o     (ph_nx),
        .cnt_o    (cnt_nx),
        .bad_o    (bad_nx)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.crc    = INIT;
            st_d.cnt    = '0;
            st_d.ok     = 1'b0;
            st_d.err    = 1'b0;
            st_d.done   = 1'b0;
            st_d.kind   = kind_in;
            st_d.pec_en = pec_en_i;
            st_d.ferr   = (kind_in == K_BAD);
            st_d.ph     = (kind_in == K_BAD) ? PH_FAULT : PH_ADDR_W;
        end else if (rstart_i) begin
            if (st_q.ph == PH_WAIT_RS) begin
                st_d.ph = PH_ADDR_R;
            end else if (st_q.ph != PH_IDLE) begin
                st_d.ph   = PH_FAULT;
                st_d.ferr = 1'b1;
            end
        end else if (stop_i) begin
            if (st_q.ph != PH_IDLE) begin
                if (st_q.ph != PH_DONE && st_q.ph != PH_FAULT) begin
                    st_d.ferr = 1'b1;
                end
                st_d.ph = PH_IDLE;
            end
        end else if (byte_valid_i && st_q.ph != PH_IDLE) begin
            if (st_q.ph != PH_PEC) begin
                st_d.crc = crc_nx;
            end else if (is_read(st_q.kind)) begin
                if (byte_i == st_q.crc) st_d.ok  = 1'b1;
                else                    st_d.err = 1'b1;
            end
            st_d.ph  = ph_nx;
            st_d.cnt = cnt_nx;
            if (bad_nx)            st_d.ferr = 1'b1;
            if (ph_nx == PH_DONE)  st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph     <= PH_IDLE;
            st_q.kind   <= K_SEND;
            st_q.pec_en <= 1'b0;
            st_q.cnt    <= '0;
            st_q.crc    <= INIT;
            st_q.ok     <= 1'b0;
            st_q.err    <= 1'b0;
            st_q.done   <= 1'b0;
            st_q.ferr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o       = st_q.crc;
    assign pec_slot_o  = (st_q.ph == PH_PEC);
    assign pec_ok_o    = st_q.ok;
    assign pec_err_o   = st_q.err;
    assign done_o      = st_q.done;
    assign frame_err_o = st_q.ferr;
endmodule

// File: rtl/smbus_pec_tracker_chk.sv
module smbus_pec_tracker_chk #(
    parameter logic [7:0] INIT = 8'h00
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_valid_i,
    input logic [2:0] txn_type_i,
    input logic [7:0] crc_o,
    input logic       pec_slot_o,
    input logic       pec_ok_o,
    input logic       pec_err_o,
    input logic       done_o,
    input logic       frame_err_o
);
    assert_crc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid_i && !start_i) |=> $stable(crc_o));

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (crc_o == INIT) && !pec_ok_o && !pec_err_o && !done_o);

    assert_start_good_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && txn_type_i != 3'd7) |=> !frame_err_o);

    assert_slot_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pec_slot_o && done_o));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pec_ok_o && pec_err_o));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_err_o && !start_i) |=> pec_err_o);

    assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_o && !start_i) |=> frame_err_o);
endmodule

bind smbus_pec_tracker smbus_pec_tracker_chk #(.INIT(INIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .txn_type_i   (txn_type_i),
    .crc_o        (crc_o),
    .pec_slot_o   (pec_slot_o),
    .pec_ok_o     (pec_ok_o),
    .pec_err_o    (pec_err_o),
    .done_o       (done_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/sim_smbus_pec_tracker.sv
module sim_smbus_pec_tracker;
    localparam int MAXB = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, rstart_i = 1'b0, stop_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic [2:0] txn_type_i = '0;
    logic       pec_en_i = 1'b0;
    logic [7:0] crc_o;
    logic       pec_slot_o, pec_ok_o, pec_err_o, done_o, frame_err_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] crc_m;

    always #2.5 clk = ~clk;

    smbus_pec_tracker #(.MAX_BLOCK(MAXB)) u0 (.*);

    function automatic logic [7:0] crc_upd(logic [7:0] c, logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic check(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_byte(logic [7:0] b, bit also_start);
        @(negedge clk);
        byte_valid_i = 1'b1; byte_i = b; start_i = also_start;
        @(negedge clk);
        byte_valid_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic send_b(logic [7:0] b);
        crc_m = crc_upd(crc_m, b);
        pulse_byte(b, 1'b0);
        check(crc_o, crc_m, "R1 crc after byte");
    endtask

    task automatic do_start(logic [2:0] t, logic pe);
        @(negedge clk);
        start_i = 1'b1; txn_type_i = t; pec_en_i = pe;
        @(negedge clk);
        start_i = 1'b0; txn_type_i = $urandom; pec_en_i = $urandom;
        crc_m = 8'h00;
    endtask

    task automatic do_rs();
        @(negedge clk); rstart_i = 1'b1;
        @(negedge clk); rstart_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic run_txn(logic [2:0] t, logic pe, int nblk, bit corrupt);
        logic [6:0] a = 7'($urandom);
        bit rd = (t >= 3'd4);
        int nd;
        do_start(t, pe);
        check(crc_o, 0, "R2 crc cleared at start");
        check(frame_err_o, 0, "R2 flags cleared at start");
        send_b({a, 1'b0});
        if (t != 3'd0) send_b(8'($urandom));
        if (rd) begin
            do_rs();
            check(crc_o, crc_m, "R3 repeated start keeps crc");
            send_b({a, 1'b1});
        end
        case (t)
            3'd0, 3'd1, 3'd4: nd = 1;
            3'd2, 3'd5:       nd = 2;
            default: begin nd = nblk; send_b(8'(nblk)); end
        endcase
        for (int i = 0; i < nd; i++) begin
            if (pe) check(pec_slot_o, 0, "R5 no slot before last data");
            send_b(8'($urandom));
        end
        if (pe) begin
            check(pec_slot_o, 1, (t == 3'd3 || t == 3'd6) ? "R6 slot after block data" : "R4 slot position");
            check(done_o, 0, "R5 not done before pec");
            pulse_byte((rd && corrupt) ? (crc_m ^ 8'h5a) : crc_m, 1'b0);
            check(crc_o, crc_m, "R5 pec byte not folded");
            check(done_o, 1, "R5 done after pec");
            if (rd) begin
                check(pec_ok_o, corrupt ? 0 : 1, "R7 pec_ok");
                check(pec_err_o, corrupt ? 1 : 0, "R7 pec_err");
            end
        end else begin
            check(pec_slot_o, 0, "R8 no slot when pec off");
            check(done_o, 1, "R8 done after last data");
        end
        do_stop();
        check(frame_err_o, 0, "R9 clean transaction");
        if (rd && corrupt && pe) check(pec_err_o, 1, "R7 pec_err held after stop");
    endtask

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check(crc_o, 0, "R2 reset crc");
        check(done_o | frame_err_o | pec_ok_o | pec_err_o | pec_slot_o, 0, "R2 reset flags");
        rst_n = 1'b1;

        // R10: bytes before any start
        pulse_byte(8'hA5, 1'b0);
        pulse_byte(8'h3C, 1'b0);
        check(crc_o, 0, "R10 bytes ignored before start");

        // R1: check vector "123456789" -> 0xF4 (block write with too large count, R12 keeps folding)
        do_start(3'd3, 1'b0);
        for (int i = 0; i < 9; i++) pulse_byte(8'h31 + 8'(i), 1'b0);
        check(crc_o, 8'hF4, "R1 check vector");
        check(frame_err_o, 1, "R6 count above limit");
        check(crc_o, 8'hF4, "R12 folding after fault");

        // R9: type 7
        do_start(3'd7, 1'b1);
        check(frame_err_o, 1, "R9 invalid type");

        // R11: start with byte in same cycle
        @(negedge clk);
        start_i = 1'b1; txn_type_i = 3'd1; pec_en_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'hEE;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
        check(crc_o, 0, "R11 byte dropped with start");

        // R3: repeated start inside a write
        do_start(3'd1, 1'b1);
        pulse_byte(8'h20, 1'b0);
        do_rs();
        check(frame_err_o, 1, "R3 misplaced repeated start");

        // R9: byte while awaiting repeated start
        do_start(3'd4, 1'b1);
        pulse_byte(8'h20, 1'b0);
        pulse_byte(8'h01, 1'b0);
        check(frame_err_o, 0, "R9 no error yet");
        pulse_byte(8'h21, 1'b0);
        check(frame_err_o, 1, "R9 byte awaiting repeated start");

        // R9: extra byte after done
        crc_m = 8'h00;
        do_start(3'd0, 1'b0);
        pulse_byte(8'h40, 1'b0);
        pulse_byte(8'h41, 1'b0);
        check(done_o, 1, "R4 send byte done");
        pulse_byte(8'h42, 1'b0);
        check(frame_err_o, 1, "R9 extra byte");

        // R9: stop before complete
        do_start(3'd2, 1'b1);
        pulse_byte(8'h40, 1'b0);
        do_stop();
        check(frame_err_o, 1, "R9 early stop");

        // R6: zero-count and max-count blocks
        run_txn(3'd3, 1'b1, 0, 1'b0);
        run_txn(3'd6, 1'b1, 0, 1'b1);
        run_txn(3'd6, 1'b0, MAXB, 1'b0);
        run_txn(3'd3, 1'b1, MAXB, 1'b0);

        // random mix of every legal type
        for (int k = 0; k < 120; k++) begin
            run_txn(3'($urandom_range(0, 6)), 1'($urandom), $urandom_range(0, MAXB),
                    ($urandom_range(0, 3) == 0));
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule